// File: doc/BRIEF.md
# Triggered Register-List Replayer

The block replays a list of register writes that software has prepared in memory. Each list entry is a descriptor of two 32-bit words: the first word is the target register address and the second is the value to write there. Software sets a start byte address, an inclusive end byte address and a trigger mode through a small CSR write port. Each accepted trigger makes the engine read the descriptors in buffer order through a word-read memory port and issue one write per descriptor on a register-write master port.

A trigger can be a rising edge of the vsync input, a rising edge of a line-count match, or a manual kick written through the CSR port. After a replay is armed it stays armed, so every qualifying event runs the list again from the start address. When the final descriptor has been written, a sticky done interrupt is raised. A window that is malformed is rejected at trigger time and sets an error flag. A software reset stops the engine and returns it to idle.

The register-write port is valid/ready. When `wr_valid` is high and `wr_ready` is low, the master holds `wr_valid`, `wr_addr` and `wr_data` unchanged, and the write counts only in a cycle where both are high. The slave can stall for any number of cycles. The memory port is a one-cycle `mem_req` pulse with `mem_addr`, answered after any latency by a one-cycle `mem_valid` with `mem_rdata`. Only one read is outstanding at a time, so the memory side never sees back-pressure.

Top module: `reglist_replay`

## Requirements
- R1: Each descriptor is two words. The word at byte offset +0 gives `wr_addr` and the word at offset +4 gives `wr_data` of a single register write.
- R2: Descriptor reads go in ascending order from the start address. The reads of one descriptor are at p and p+4, then the next descriptor is at p+8, and no read falls outside [start, end].
- R3: The end address is inclusive. A window with end = start + 8*N - 1 produces exactly N register writes.
- R4: An armed mode stays armed. Every further qualifying event replays the whole list again from the start address.
- R5: `irq_done` rises after the final write of a replay is accepted, and it stays high until it is cleared.
- R6: A CSR write to address 0 with bit 1 set clears `irq_done`. A CSR write to address 0 with bit 2 set clears `err_flag`.
- R7: A trigger that arrives while `busy` is high is ignored, and the replay in progress is neither restarted nor lengthened.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay stable.
- R9: Trigger mode 0 (stop), written to CSR address 3 bits [1:0], disarms the block, so vsync edges start no replay.
- R10: In trigger mode 2, a rising edge of (`line_cnt` == line target at CSR address 4) starts a replay. In mode 1, a rising edge of `vsync` starts a replay.
- R11: Writing mode 3 (manual) to CSR address 3 starts one replay per such write.
- R12: A trigger whose window has end < start, or whose length end - start + 1 is not a multiple of 8, starts no replay and sets `err_flag`.
- R13: A CSR write to address 0 with bit 0 set (software reset) drops `busy` on the next cycle, ends all further writes of the replay in progress, and clears `irq_done` and `err_flag`. The start and end addresses are at CSR addresses 1 and 2.
- R14: At most one memory read is outstanding. A new `mem_req` is issued only after the previous one has returned `mem_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 3 | CSR select: 0 control, 1 start, 2 end, 3 mode, 4 line target |
| csr_wdata | input | AW | CSR write data |
| vsync | input | 1 | Frame sync; its rising edge is an event in mode 1 |
| line_cnt | input | LINE_W | Current line number |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | AW | Read byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data word |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | DW | Register address taken from the descriptor |
| wr_data | output | DW | Register value taken from the descriptor |
| busy | output | 1 | A replay is in progress |
| irq_done | output | 1 | Sticky done interrupt |
| err_flag | output | 1 | Sticky bad-window status |

## Verification
The assertions check the following on every cycle: the write port holds steady under back-pressure, only one memory read is in flight, every read address lies inside the programmed window, the done interrupt falls only after a clear or reset write, no replay starts in stop mode, and the engine is idle one cycle after a software reset. Some behaviours can only be shown by the directed scenarios: that the descriptor words map to address and data in the right order, that the inclusive window gives the exact write count, that a trigger arriving mid-replay is dropped, that re-arming works, that line-match and manual triggers work, that bad windows are rejected, and that a restart after reset begins from the start address.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic [1:0] {
    TRIG_STOP   = 2'd0,
    TRIG_VSYNC  = 2'd1,
    TRIG_LINE   = 2'd2,
    TRIG_MANUAL = 2'd3
  } trig_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ_A, S_WAIT_A, S_REQ_D, S_WAIT_D, S_WRITE
  } eng_state_e;

  localparam logic [2:0] CSR_CTRL  = 3'd0;
  localparam logic [2:0] CSR_START = 3'd1;
  localparam logic [2:0] CSR_END   = 3'd2;
  localparam logic [2:0] CSR_MODE  = 3'd3;
  localparam logic [2:0] CSR_LINE  = 3'd4;

  localparam int CTRL_SRST   = 0;
  localparam int CTRL_IRQCLR = 1;
  localparam int CTRL_ERRCLR = 2;
endpackage

// File: rtl/rr_csr.sv
module rr_csr
  import rr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [2:0]        csr_addr,
  input  logic [AW-1:0]     csr_wdata,
  output logic [AW-1:0]     start_q,
  output logic [AW-1:0]     end_q,
  output trig_mode_e        mode_q,
  output logic [LINE_W-1:0] line_q,
  output logic              kick_q,
  output logic              soft_rst,
  output logic              irq_clr,
  output logic              err_clr
);
  logic ctrl_wr;
  assign ctrl_wr  = csr_we && (csr_addr == CSR_CTRL);
  assign soft_rst = ctrl_wr && csr_wdata[CTRL_SRST];
  assign irq_clr  = ctrl_wr && csr_wdata[CTRL_IRQCLR];
  assign err_clr  = ctrl_wr && csr_wdata[CTRL_ERRCLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      mode_q  <= TRIG_STOP;
      line_q  <= '0;
      kick_q  <= 1'b0;
    end else begin
      kick_q <= 1'b0;
      if (csr_we) begin
        unique case (csr_addr)
          CSR_START: start_q <= csr_wdata;
          CSR_END:   end_q   <= csr_wdata;
          CSR_MODE: begin
            mode_q <= trig_mode_e'(csr_wdata[1:0]);
            kick_q <= (csr_wdata[1:0] == TRIG_MANUAL);
          end
          CSR_LINE:  line_q  <= csr_wdata[LINE_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rr_trigger.sv
module rr_trigger
  import rr_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trig_mode_e        mode,
  input  logic              vsync,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic [LINE_W-1:0] line_tgt,
  input  logic              kick,
  output logic              fire
);
  logic vs_q, hit, hit_q;
  assign hit = (line_cnt == line_tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q  <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      vs_q  <= vsync;
      hit_q <= hit;
    end
  end

  always_comb begin
    unique case (mode)
      TRIG_VSYNC:  fire = vsync && !vs_q;
      TRIG_LINE:   fire = hit && !hit_q;
      TRIG_MANUAL: fire = kick;
      default:     fire = 1'b0;
    endcase
  end
endmodule

// File: rtl/rr_engine.sv
module rr_engine
  import rr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          fire,
  input  logic [AW-1:0] win_start,
  input  logic [AW-1:0] win_end,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          done,
  output logic          bad
);
  localparam logic [AW-1:0] WORD_B = AW'(4);
  localparam logic [AW-1:0] DESC_B = AW'(8);
  localparam logic [AW-1:0] LAST_B = DESC_B - AW'(1);

  eng_state_e    st;
  logic [AW-1:0] ptr, lim, span;
  logic          win_ok, last;

  assign span   = win_end - win_start + AW'(1);
  assign win_ok = (win_end >= win_start) && (span[2:0] == 3'b000);
  assign last   = (ptr + LAST_B == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr     <= '0;
      lim     <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (soft_rst) begin
      st  <= S_IDLE;
      ptr <= '0;
      lim <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (fire && win_ok) begin
          ptr <= win_start;
          lim <= win_end;
          st  <= S_REQ_A;
        end
        S_REQ_A:  st <= S_WAIT_A;
        S_WAIT_A: if (mem_valid) begin
          wr_addr <= mem_rdata;
          st      <= S_REQ_D;
        end
        S_REQ_D:  st <= S_WAIT_D;
        S_WAIT_D: if (mem_valid) begin
          wr_data <= mem_rdata;
          st      <= S_WRITE;
        end
        S_WRITE: if (wr_ready) begin
          if (last) st <= S_IDLE;
          else begin
            ptr <= ptr + DESC_B;
            st  <= S_REQ_A;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req  = (st == S_REQ_A) || (st == S_REQ_D);
  assign mem_addr = (st == S_REQ_D) ? ptr + WORD_B : ptr;
  assign wr_valid = (st == S_WRITE);
  assign busy     = (st != S_IDLE);
  assign done     = wr_valid && wr_ready && last && !soft_rst;
  assign bad      = (st == S_IDLE) && fire && !win_ok && !soft_rst;
endmodule

// File: rtl/reglist_replay.sv
module reglist_replay
  import rr_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [2:0]        csr_addr,
  input  logic [AW-1:0]     csr_wdata,
  input  logic              vsync,
  input  logic [LINE_W-1:0] line_cnt,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_valid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              busy,
  output logic              irq_done,
  output logic              err_flag
);
  logic [AW-1:0]     start_q, end_q;
  trig_mode_e        mode_q;
  logic [LINE_W-1:0] line_q;
  logic              kick_q, soft_rst, irq_clr, err_clr;
  logic              fire, done, bad;

  rr_csr #(.AW(AW), .LINE_W(LINE_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .start_q(start_q), .end_q(end_q),
    .mode_q(mode_q), .line_q(line_q), .kick_q(kick_q),
    .soft_rst(soft_rst), .irq_clr(irq_clr), .err_clr(err_clr)
  );

  rr_trigger #(.LINE_W(LINE_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .vsync(vsync),
    .line_cnt(line_cnt), .line_tgt(line_q), .kick(kick_q), .fire(fire)
  );

  rr_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fire(fire),
    .win_start(start_q), .win_end(end_q),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
    .done(done), .bad(bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_done <= 1'b0;
      err_flag <= 1'b0;
    end else if (soft_rst) begin
      irq_done <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (done)         irq_done <= 1'b1;
      else if (irq_clr) irq_done <= 1'b0;
      if (bad)          err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rr_check.sv
module rr_check
  import rr_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_valid,
  input logic [AW-1:0] mem_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [DW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          irq_done,
  input logic          csr_we,
  input logic [2:0]    csr_addr,
  input logic [AW-1:0] csr_wdata,
  input logic [AW-1:0] win_lo,
  input logic [AW-1:0] win_hi,
  input trig_mode_e    mode,
  input logic          busy,
  input logic          soft_rst
);
  logic in_flight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_flight <= 1'b0;
    else if (soft_rst) in_flight <= 1'b0;
    else if (mem_req) in_flight <= 1'b1;
    else if (mem_valid) in_flight <= 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n && !soft_rst)
      a_r14_one_outstanding: assert (!(mem_req && in_flight))
        else $error("second read issued while one outstanding");
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r2_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr >= win_lo && mem_addr <= win_hi));

  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_done) |-> $past(csr_we && csr_addr == CSR_CTRL &&
                              (csr_wdata[CTRL_SRST] || csr_wdata[CTRL_IRQCLR])));

  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_STOP && !busy) |=> !busy);

  a_r13_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy);
endmodule

bind reglist_replay rr_check #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_valid(mem_valid),
  .mem_addr(mem_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .irq_done(irq_done),
  .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
  .win_lo(start_q), .win_hi(end_q), .mode(mode_q), .busy(busy),
  .soft_rst(soft_rst)
);

// File: tb/sim_reglist_replay.sv
`timescale 1ns/1ps
module sim_reglist_replay;
  localparam int AW = 32, DW = 32, LW = 12, LAT = 2;
  localparam logic [31:0] BASE = 32'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_we = 1'b0;
  logic [2:0] csr_addr = '0;
  logic [AW-1:0] csr_wdata = '0;
  logic vsync = 1'b0;
  logic [LW-1:0] line_cnt = '0;
  logic mem_req, mem_valid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic wr_valid, wr_ready = 1'b1;
  logic [DW-1:0] wr_addr, wr_data;
  logic busy, irq_done, err_flag;

  always #2.5 clk = ~clk;

  reglist_replay #(.AW(AW), .DW(DW), .LINE_W(LW)) u0 (.*);

  int total = 0, bad = 0, cyc = 0;
  logic bp = 1'b0;

  // memory model: one-cycle response after LAT cycles
  logic [31:0] mem [0:255];
  logic pend = 1'b0;
  logic [31:0] paddr = '0;
  int pcnt = 0;
  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (mem_req) begin pend <= 1'b1; paddr <= mem_addr; pcnt <= LAT; end
    else if (pend) begin
      if (pcnt == 1) begin
        mem_valid <= 1'b1; mem_rdata <= mem[paddr[9:2]]; pend <= 1'b0;
      end
      pcnt <= pcnt - 1;
    end
  end

  // write log
  logic [31:0] log_a [0:255];
  logic [31:0] log_d [0:255];
  int wcount = 0;
  always @(posedge clk) if (rst_n && wr_valid && wr_ready) begin
    log_a[wcount] <= wr_addr; log_d[wcount] <= wr_data; wcount <= wcount + 1;
  end

  always @(negedge clk) wr_ready <= bp ? ((cyc % 3) == 0) : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  function automatic logic [31:0] exp_a(int i); return 32'hC000_0000 | (i << 2); endfunction
  function automatic logic [31:0] exp_d(int i); return 32'h1234_0000 + i * 32'h0101; endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic set_win(input int n);
    csr_wr(3'd1, BASE); csr_wr(3'd2, BASE + 8 * n - 1);
  endtask

  task automatic pulse_vs();
    @(negedge clk); vsync = 1'b1; @(negedge clk); vsync = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3000 && busy; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_run(input int b, input int n, input string req);
    chk(wcount - b == n, req, wcount - b, n);
    for (int i = 0; i < n && i < wcount - b; i++) begin
      chk(log_a[b + i] == exp_a(i), req, log_a[b + i], exp_a(i));
      chk(log_d[b + i] == exp_d(i), req, log_d[b + i], exp_d(i));
    end
  endtask

  task automatic t_reset();
    chk(!busy && !irq_done && !err_flag && !wr_valid && !mem_req, "R5 reset state",
        {busy, irq_done, err_flag, wr_valid, mem_req}, 0);
  endtask

  task automatic t_vsync();  // R1 R2 R3 R5 R6 R10
    int b = wcount;
    set_win(3); csr_wr(3'd3, 1);
    chk(!irq_done, "R5 irq low before", irq_done, 0);
    pulse_vs(); wait_idle();
    check_run(b, 3, "R1/R3 vsync replay");
    chk(irq_done, "R5 irq set", irq_done, 1);
    repeat (5) @(negedge clk);
    chk(irq_done, "R5 irq sticky", irq_done, 1);
    csr_wr(3'd0, 32'h2);
    chk(!irq_done, "R6 irq clear", irq_done, 0);
  endtask

  task automatic t_busy_rearm();  // R7 R4
    int b = wcount;
    pulse_vs(); repeat (5) @(negedge clk); pulse_vs(); wait_idle();
    repeat (10) @(negedge clk);
    check_run(b, 3, "R7 trigger while busy");
    b = wcount;
    pulse_vs(); wait_idle();
    check_run(b, 3, "R4 rearmed replay");
  endtask

  task automatic t_backpressure();  // R8 R2
    int b = wcount;
    set_win(5); bp = 1'b1;
    pulse_vs(); wait_idle(); bp = 1'b0;
    check_run(b, 5, "R8 backpressure order");
  endtask

  task automatic t_stop();  // R9
    int b = wcount;
    csr_wr(3'd3, 0); pulse_vs(); repeat (30) @(negedge clk);
    chk(wcount == b && !busy, "R9 stop disarms", wcount - b, 0);
  endtask

  task automatic t_line();  // R10
    int b = wcount;
    set_win(2); csr_wr(3'd4, 5); csr_wr(3'd3, 2);
    for (int l = 0; l < 10; l++) begin @(negedge clk); line_cnt = LW'(l); end
    wait_idle();
    check_run(b, 2, "R10 line match");
    line_cnt = '0;
  endtask

  task automatic t_manual();  // R11
    int b = wcount;
    set_win(4); csr_wr(3'd3, 3); wait_idle();
    check_run(b, 4, "R11 manual start");
    b = wcount;
    csr_wr(3'd3, 3); wait_idle();
    check_run(b, 4, "R11 manual again");
  endtask

  task automatic t_badwin();  // R12 R6
    int b = wcount;
    csr_wr(3'd1, BASE); csr_wr(3'd2, BASE - 1); csr_wr(3'd3, 3);
    repeat (20) @(negedge clk);
    chk(err_flag && wcount == b, "R12 end below start", {err_flag, 8'(wcount - b)}, 32'h100);
    csr_wr(3'd0, 32'h4);
    chk(!err_flag, "R6 err clear", err_flag, 0);
    csr_wr(3'd2, BASE + 11); csr_wr(3'd3, 3);
    repeat (20) @(negedge clk);
    chk(err_flag && wcount == b, "R12 misaligned", {err_flag, 8'(wcount - b)}, 32'h100);
  endtask

  task automatic t_softrst();  // R13
    int b = wcount, n0;
    set_win(4); csr_wr(3'd3, 1); pulse_vs();
    for (int k = 0; k < 500 && wcount == b; k++) @(negedge clk);
    csr_wr(3'd0, 32'h1);
    n0 = wcount;
    repeat (20) @(negedge clk);
    chk(!busy && !err_flag && wcount == n0 && n0 - b < 4, "R13 soft reset stops",
        {busy, err_flag, 8'(wcount - n0)}, 0);
    b = wcount;
    pulse_vs(); wait_idle();
    check_run(b, 4, "R13 restart from start");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + i;
    for (int i = 0; i < 16; i++) begin
      mem[(BASE >> 2) + 2 * i]     = exp_a(i);
      mem[(BASE >> 2) + 2 * i + 1] = exp_d(i);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_vsync();
    t_busy_rearm();
    t_backpressure();
    t_stop();
    t_line();
    t_manual();
    t_badwin();
    t_softrst();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule